// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a processor port and a lower-level memory. It holds 32 lines of 32 bytes each, which is 1 KiB. The processor issues 32-bit word reads and byte-masked word writes on a 32-bit address, and it holds each request until `cpuReady` pulses. A read that hits returns its word in the same cycle as the tag compare. A write that hits changes the stored line only in the cycle after the tag check has confirmed the hit.

The memory side moves whole 256-bit lines with a request/acknowledge pair. On a miss the controller first writes the victim line back if that line is dirty. It then fetches the new line and replays the access. Whether a write miss allocates a line is set by the `WRITE_ALLOCATE` parameter. When allocation is off, a write miss is forwarded to memory as a byte-masked write and the cache stays unchanged.

Top module: `cache_wb_top`

## Requirements
- R1: After reset every line is invalid and clean, so the first access to any address misses and causes a line fetch.
- R2: Address bits [4:0] pick the byte within the line, bits [9:5] pick one of the 32 lines, and bits [31:10] form the 22-bit tag. Two addresses with equal index and different tags compete for one line. Addresses with different indices are held at the same time.
- R3: A read hits when the indexed line is valid and its tag equals the address tag. `cpuReady` and `cpuHit` are then high in the same cycle as the request, `cpuRdata` carries the 32-bit word selected by address bits [4:2], and no memory request is made.
- R4: A write hit raises `cpuReady` one cycle after the request is presented (tag check first, line update second) and makes no memory request.
- R5: A write changes only the bytes whose `cpuBe[k]` is set. Byte k is bits 8k+7:8k of the word. All other bytes of the line keep their values.
- R6: A miss whose victim line is dirty first issues a memory write (`memWe`=1, all 32 `memByteEn` bits set) of the whole old line to address {old tag, index, 5'b0}. Only after that write is acknowledged does the controller fetch the new line.
- R7: A miss whose victim is clean or invalid issues no write-back, and a freshly fetched line is clean.
- R8: A line fetch is a memory read at the line-aligned address. `memReq` is held until `memAck`, the line on `memRline` is captured in the acknowledge cycle, and the access is then completed with `cpuReady`.
- R9: With `WRITE_ALLOCATE`=1, a write miss fetches the line, merges the write into it and leaves the line dirty, so a following read of that word hits.
- R10: With `WRITE_ALLOCATE`=0, a write miss issues one memory write whose `memByteEn` bits 4w+k are set for word w = address[4:2] and each enabled byte k. The cache contents stay unchanged, so a following read of that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address of the word |
| cpuWdata | input | 32 | Write data |
| cpuBe | input | 4 | Byte enables of the write |
| cpuRdata | output | 32 | Read data of the addressed word |
| cpuReady | output | 1 | Access completes at the next clock edge |
| cpuHit | output | 1 | Indexed line is valid and its tag matches |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | 1 = memory write, 0 = line read |
| memAddr | output | 32 | Line-aligned memory address |
| memWline | output | 256 | Write data, one full line |
| memByteEn | output | 32 | Byte lanes to write in memory |
| memRline | input | 256 | Line returned by memory |
| memAck | input | 1 | Memory has completed the request |

## Verification
A read hit is due in the request cycle itself, a write hit one cycle later, and a miss only after the memory acknowledges (twice when a dirty victim is written back first). The bench presents each request just after a falling edge and samples `cpuReady` a little later. It counts the falling edges that pass before `cpuReady` appears and compares that count with 0 for a read hit and 1 for a write hit. Memory traffic is counted at the rising edges where `memAck` completes a request. Every written-back line is compared there with a bench reference image of memory.

// File: rtl/cache_wb_pkg.sv
package cache_wb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WHIT,
    S_WBACK,
    S_FILL,
    S_NAWR
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic writeWord;     // merge processor write into the indexed line
    logic fillLine;      // load line from memory, set valid, clear dirty
    logic victimSel;     // memory port carries the victim line
  } dp_strobe_t;

endpackage

// File: rtl/cache_wb_datapath.sv
module cache_wb_datapath
  import cache_wb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dp_strobe_t                 strobe,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [8*WORD_BYTES-1:0]    cpuWdata,
  input  logic [WORD_BYTES-1:0]      cpuBe,
  input  logic [8*LINE_BYTES-1:0]    memRline,
  output logic                       lookupHit,
  output logic                       victimDirty,
  output logic [8*WORD_BYTES-1:0]    cpuRdata,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [8*LINE_BYTES-1:0]    memWline,
  output logic [LINE_BYTES-1:0]      memByteEn
);

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BSEL_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = OFF_W - BSEL_W;

  logic [LINE_W-1:0] lineMem [NUM_LINES];
  logic [TAG_W-1:0]  tagMem  [NUM_LINES];
  logic [NUM_LINES-1:0] validBits;
  logic [NUM_LINES-1:0] dirtyBits;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  addrTag;
  logic [WSEL_W-1:0] wsel;
  logic [LINE_W-1:0] curLine;
  logic [TAG_W-1:0]  curTag;
  logic [LINE_W-1:0] mergedLine;
  logic [LINE_W-1:0] wdataRep;
  logic [LINE_BYTES-1:0] laneEn;

  assign idx     = cpuAddr[OFF_W +: IDX_W];
  assign addrTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wsel    = cpuAddr[BSEL_W +: WSEL_W];
  assign curLine = lineMem[idx];
  assign curTag  = tagMem[idx];

  // tag compare and word select in the same cycle
  assign lookupHit   = validBits[idx] && (curTag == addrTag);
  assign victimDirty = validBits[idx] && dirtyBits[idx];
  assign cpuRdata    = curLine[WORD_W*wsel +: WORD_W];

  // per byte lane: enable, merge and replication
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign laneEn[b] = (wsel == WSEL_W'(b / WORD_BYTES)) && cpuBe[b % WORD_BYTES];
    assign wdataRep[8*b +: 8]   = cpuWdata[8*(b % WORD_BYTES) +: 8];
    assign mergedLine[8*b +: 8] = laneEn[b] ? cpuWdata[8*(b % WORD_BYTES) +: 8]
                                            : curLine[8*b +: 8];
  end

  assign memAddr   = strobe.victimSel ? {curTag, idx, {OFF_W{1'b0}}}
                                      : {cpuAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memWline  = strobe.victimSel ? curLine : wdataRep;
  assign memByteEn = strobe.victimSel ? {LINE_BYTES{1'b1}} : laneEn;

  always_ff @(posedge clk) begin
    if (strobe.fillLine) begin
      lineMem[idx] <= memRline;
      tagMem[idx]  <= addrTag;
    end else if (strobe.writeWord) begin
      lineMem[idx] <= mergedLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else if (strobe.fillLine) begin
      validBits[idx] <= 1'b1;
      dirtyBits[idx] <= 1'b0;
    end else if (strobe.writeWord) begin
      dirtyBits[idx] <= 1'b1;
    end
  end

  // R1: state bits are empty when reset is released
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (validBits == '0 && dirtyBits == '0));

  // R4: a line is only modified after a confirmed hit
  p_write_on_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeWord |-> lookupHit);

  // R9: a merged write leaves its line dirty
  p_write_dirty_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeWord |=> dirtyBits[$past(idx)]);

  // R7: a fetched line is valid and clean
  p_fill_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLine |=> (validBits[$past(idx)] && !dirtyBits[$past(idx)]));

endmodule

// File: rtl/cache_wb_control.sv
module cache_wb_control
  import cache_wb_pkg::*;
#(
  parameter bit WRITE_ALLOCATE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       lookupHit,
  input  logic       victimDirty,
  input  logic       memAck,
  output dp_strobe_t strobe,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);

  ctrl_state_e stateQ, stateD;
  logic bypassWrite;

  // allocation policy on a write miss
  if (WRITE_ALLOCATE) begin : g_alloc
    assign bypassWrite = 1'b0;
  end else begin : g_noalloc
    assign bypassWrite = cpuWe;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        if (cpuReq) begin
          if (lookupHit) begin
            if (cpuWe) stateD = S_WHIT;
          end else if (bypassWrite) begin
            stateD = S_NAWR;
          end else if (victimDirty) begin
            stateD = S_WBACK;
          end else begin
            stateD = S_FILL;
          end
        end
      end
      S_WHIT:  stateD = S_IDLE;
      S_WBACK: if (memAck) stateD = S_FILL;
      S_FILL:  if (memAck) stateD = S_IDLE;
      S_NAWR:  if (memAck) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign cpuReady = (stateQ == S_IDLE && cpuReq && lookupHit && !cpuWe)
                  || (stateQ == S_WHIT)
                  || (stateQ == S_NAWR && memAck);
  assign memReq   = (stateQ == S_WBACK) || (stateQ == S_FILL) || (stateQ == S_NAWR);
  assign memWe    = (stateQ == S_WBACK) || (stateQ == S_NAWR);

  assign strobe.writeWord = (stateQ == S_WHIT);
  assign strobe.fillLine  = (stateQ == S_FILL) && memAck;
  assign strobe.victimSel = (stateQ == S_WBACK);

  // R3: a completed read always comes from a hit line
  p_read_from_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !cpuWe) |-> lookupHit);

  // R6: write-back happens only for a dirty victim
  p_wb_dirty_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WBACK) |-> victimDirty);

  // R6: an acknowledged write-back is followed by a line read
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WBACK && memAck) |=> (memReq && !memWe));

  // R8: a memory request is held until acknowledged
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

endmodule

// File: rtl/cache_wb_top.sv
module cache_wb_top
  import cache_wb_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int WORD_BYTES     = 4,
  parameter int LINE_BYTES     = 32,
  parameter int NUM_LINES      = 32,
  parameter bit WRITE_ALLOCATE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [8*WORD_BYTES-1:0] cpuWdata,
  input  logic [WORD_BYTES-1:0]   cpuBe,
  output logic [8*WORD_BYTES-1:0] cpuRdata,
  output logic                    cpuReady,
  output logic                    cpuHit,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [8*LINE_BYTES-1:0] memWline,
  output logic [LINE_BYTES-1:0]   memByteEn,
  input  logic [8*LINE_BYTES-1:0] memRline,
  input  logic                    memAck
);

  dp_strobe_t strobe;
  logic lookupHit;
  logic victimDirty;

  cache_wb_control #(
    .WRITE_ALLOCATE(WRITE_ALLOCATE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .strobe     (strobe),
    .cpuReady   (cpuReady),
    .memReq     (memReq),
    .memWe      (memWe)
  );

  cache_wb_datapath #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES),
    .LINE_BYTES(LINE_BYTES),
    .NUM_LINES (NUM_LINES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .cpuBe      (cpuBe),
    .memRline   (memRline),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memWline   (memWline),
    .memByteEn  (memByteEn)
  );

  assign cpuHit = lookupHit;

endmodule

// File: tb/cache_wb_top_tb_top.sv
module cache_wb_mem_model #(
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         req,
  input  logic         we,
  input  logic [31:0]  addr,
  input  logic [255:0] wline,
  input  logic [31:0]  byteEn,
  output logic [255:0] rline,
  output logic         ack
);
  logic [255:0] store [256];
  int cnt;

  initial begin
    for (int i = 0; i < 256; i++)
      for (int b = 0; b < 32; b++)
        store[i][8*b +: 8] = 8'(i * 37 + b * 11 + 5);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      ack <= 1'b0;
      cnt <= 0;
      rline <= '0;
    end else if (ack) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (req) begin
      if (cnt == LAT) begin
        ack <= 1'b1;
        cnt <= 0;
        if (we) begin
          for (int b = 0; b < 32; b++)
            if (byteEn[b]) store[addr[12:5]][8*b +: 8] = wline[8*b +: 8];
        end else begin
          rline <= store[addr[12:5]];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module cache_wb_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqA = 1'b0, reqB = 1'b0;
  logic cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [3:0] cpuBe = '0;

  logic [31:0] rdataA, rdataB, memAddrA, memAddrB, byteEnA, byteEnB;
  logic readyA, readyB, hitA, hitB, memReqA, memReqB, memWeA, memWeB, ackA, ackB;
  logic [255:0] wlineA, wlineB, rlineA, rlineB;

  int checks = 0;
  int failures = 0;
  int fillA = 0, wrA = 0, fillB = 0, wrB = 0;
  logic [255:0] refA [256];
  logic [255:0] refB [256];

  always #10 clk = ~clk;

  cache_wb_top #(.WRITE_ALLOCATE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(reqA), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuRdata(rdataA), .cpuReady(readyA),
    .cpuHit(hitA), .memReq(memReqA), .memWe(memWeA), .memAddr(memAddrA),
    .memWline(wlineA), .memByteEn(byteEnA), .memRline(rlineA), .memAck(ackA));

  cache_wb_top #(.WRITE_ALLOCATE(1'b0)) dutNa_i (
    .clk(clk), .rstN(rstN), .cpuReq(reqB), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuRdata(rdataB), .cpuReady(readyB),
    .cpuHit(hitB), .memReq(memReqB), .memWe(memWeB), .memAddr(memAddrB),
    .memWline(wlineB), .memByteEn(byteEnB), .memRline(rlineB), .memAck(ackB));

  cache_wb_mem_model memA_i (.clk(clk), .rstN(rstN), .req(memReqA), .we(memWeA),
    .addr(memAddrA), .wline(wlineA), .byteEn(byteEnA), .rline(rlineA), .ack(ackA));
  cache_wb_mem_model memB_i (.clk(clk), .rstN(rstN), .req(memReqB), .we(memWeB),
    .addr(memAddrB), .wline(wlineB), .byteEn(byteEnB), .rline(rlineB), .ack(ackB));

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory-side monitor: traffic counts and write-back contents (R6)
  always @(posedge clk) begin
    if (rstN && memReqA && ackA) begin
      if (memWeA) begin
        wrA++;
        checks++;
        if (wlineA !== refA[memAddrA[12:5]] || byteEnA !== 32'hFFFF_FFFF
            || memAddrA[4:0] !== 5'd0) begin
          failures++;
          $display("FAIL R6 write-back line at %h actual=%h expected=%h",
                   memAddrA, wlineA, refA[memAddrA[12:5]]);
        end
      end else fillA++;
    end
    if (rstN && memReqB && ackB) begin
      if (memWeB) wrB++;
      else fillB++;
    end
  end

  function automatic logic [31:0] refWord(input bit na, input logic [31:0] a);
    logic [255:0] ln;
    ln = na ? refB[a[12:5]] : refA[a[12:5]];
    return ln[32*a[4:2] +: 32];
  endfunction

  task automatic refWrite(input bit na, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] be);
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        if (na) refB[a[12:5]][32*a[4:2] + 8*k +: 8] = d[8*k +: 8];
        else    refA[a[12:5]][32*a[4:2] + 8*k +: 8] = d[8*k +: 8];
      end
    end
  endtask

  task automatic doAccess(input bit na, input bit we, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] be,
                          output logic [31:0] rd, output logic hit, output int waits);
    bit done;
    @(negedge clk);
    cpuWe = we; cpuAddr = a; cpuWdata = d; cpuBe = be;
    if (na) reqB = 1'b1; else reqA = 1'b1;
    waits = 0;
    done = 1'b0;
    rd = '0;
    hit = 1'b0;
    while (!done) begin
      #2;
      if (na ? readyB : readyA) begin
        rd = na ? rdataB : rdataA;
        hit = na ? hitB : hitA;
        done = 1'b1;
      end else begin
        @(negedge clk);
        waits++;
      end
    end
    @(posedge clk);
    #1;
    reqA = 1'b0;
    reqB = 1'b0;
    if (we) refWrite(na, a, d, be);
  endtask

  logic [31:0] rd;
  logic hit;
  int waits;
  int f0, w0;

  initial begin
    for (int i = 0; i < 256; i++)
      for (int b = 0; b < 32; b++) begin
        refA[i][8*b +: 8] = 8'(i * 37 + b * 11 + 5);
        refB[i][8*b +: 8] = 8'(i * 37 + b * 11 + 5);
      end
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    check32("R1", "ready idle after reset", {31'b0, readyA}, 32'd0);

    // R1/R8: first read misses and fetches a line
    doAccess(0, 0, 32'h0000_0040, 0, 0, rd, hit, waits);
    check32("R1", "fill count on first read", fillA, 1);
    check32("R8", "read data after fetch", rd, refWord(0, 32'h40));
    check32("R7", "no write-back on invalid victim", wrA, 0);

    // R3: read hit in the request cycle
    doAccess(0, 0, 32'h0000_004C, 0, 0, rd, hit, waits);
    check32("R3", "read hit waits", waits, 0);
    check32("R3", "hit flag", {31'b0, hit}, 1);
    check32("R3", "read hit data word 3", rd, refWord(0, 32'h4C));
    check32("R3", "no fetch on hit", fillA, 1);

    // R4/R5: masked write hit
    doAccess(0, 1, 32'h0000_0044, 32'hA1B2_C3D4, 4'b0101, rd, hit, waits);
    check32("R4", "write hit waits", waits, 1);
    check32("R4", "no memory traffic on write hit", fillA + wrA, 1);
    doAccess(0, 0, 32'h0000_0044, 0, 0, rd, hit, waits);
    check32("R5", "masked bytes merged", rd, refWord(0, 32'h44));
    check32("R5", "lanes 1 and 3 kept", rd & 32'hFF00_FF00,
            (32'h0000_0044 == 0) ? 0 : (refWord(0, 32'h44) & 32'hFF00_FF00));
    doAccess(0, 0, 32'h0000_0040, 0, 0, rd, hit, waits);
    check32("R5", "neighbour word untouched", rd, refWord(0, 32'h40));

    // R2/R6: same index, other tag evicts dirty line
    doAccess(0, 0, 32'h0000_0440, 0, 0, rd, hit, waits);
    check32("R6", "one write-back for dirty victim", wrA, 1);
    check32("R2", "conflicting tag fetched", fillA, 2);
    check32("R2", "data of new tag", rd, refWord(0, 32'h440));

    // R7: clean victim dropped; R6 data reached memory
    doAccess(0, 0, 32'h0000_0044, 0, 0, rd, hit, waits);
    check32("R7", "no write-back of clean victim", wrA, 1);
    check32("R6", "written data back from memory", rd, refWord(0, 32'h44));

    // R9: write-allocate merge
    doAccess(0, 1, 32'h0000_0868, 32'h1234_5678, 4'b1110, rd, hit, waits);
    check32("R9", "write miss fetched line", fillA, 4);
    doAccess(0, 0, 32'h0000_0868, 0, 0, rd, hit, waits);
    check32("R9", "allocated write read hit waits", waits, 0);
    check32("R9", "merged word", rd, refWord(0, 32'h868));

    // R2: different indices coexist
    doAccess(0, 0, 32'h0000_0048, 0, 0, rd, hit, waits);
    check32("R2", "other index still resident", waits, 0);

    // random traffic on the allocating cache
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      bit we;
      a = {19'b0, 3'($urandom), 5'($urandom % 4), 3'($urandom), 2'b00};
      we = 1'($urandom);
      if (we) doAccess(0, 1, a, $urandom, 4'($urandom), rd, hit, waits);
      else begin
        doAccess(0, 0, a, 0, 0, rd, hit, waits);
        check32("R3", "random read data", rd, refWord(0, a));
      end
    end

    // R10: no-write-allocate
    doAccess(1, 1, 32'h0000_0104, 32'hDEAD_BEEF, 4'b0011, rd, hit, waits);
    check32("R10", "bypass memory write", wrB, 1);
    check32("R10", "no fetch on write miss", fillB, 0);
    doAccess(1, 0, 32'h0000_0104, 0, 0, rd, hit, waits);
    check32("R10", "cache unchanged: read misses", fillB, 1);
    check32("R10", "memory holds merged bytes", rd, refWord(1, 32'h104));

    // write hit on the non-allocating cache
    doAccess(1, 1, 32'h0000_0108, 32'h0BAD_F00D, 4'b1000, rd, hit, waits);
    check32("R4", "write hit waits no-allocate", waits, 1);
    doAccess(1, 0, 32'h0000_0108, 0, 0, rd, hit, waits);
    check32("R5", "byte 3 only", rd, refWord(1, 32'h108));

    for (int n = 0; n < 200; n++) begin
      logic [31:0] a;
      bit we;
      a = {19'b0, 3'($urandom), 5'($urandom % 4), 3'($urandom), 2'b00};
      we = 1'($urandom);
      f0 = fillB;
      w0 = wrB;
      if (we) doAccess(1, 1, a, $urandom, 4'($urandom), rd, hit, waits);
      else begin
        doAccess(1, 0, a, 0, 0, rd, hit, waits);
        check32("R10", "random read data", rd, refWord(1, a));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule